// File: doc/BRIEF.md
# Configuration Strap Latch and Clock Mode Resolver

This block captures two board configuration straps, one for the serial management address and one for the clock loop mode, and holds them for the rest of the power cycle. Each strap comes from a three-level pad sensor that has already reduced the pad voltage to a 2-bit level code. The capture happens once, in the first clock cycle after reset in which the active-low power-down input is high. Later power-down entries and exits leave the captured values alone.

From the held values the block supplies the low bits of the management bus address to the serial slave, a read-only mode code for the register file, and the operating mode that the loop control uses. Software can override the mode and the output frequency code, each through its own enable bit. The readback code always shows the strap and never the override. A valid flag tells the serial slave when the address is usable. Until the first capture the slave stays silent.

Top module: `strap_mode_ctrl`

## Requirements
- R1: `straps_valid` is 0 after reset. It rises one clock after the first sampled cycle with `pd_n` = 1 and stays 1 until the next reset.
- R2: Both straps are sampled in that same cycle. Strap changes, and `pd_n` falling and rising again, have no effect on `addr_low` or `mode_readback` until the next reset.
- R3: A strap level code of 2'b00 means low, 2'b01 means mid, and 2'b10 or 2'b11 means high.
- R4: `addr_low` is 3'b011, 3'b100 or 3'b101 for a captured address strap of low, mid or high. It is 3'b000 while `straps_valid` is 0.
- R5: `mode_readback` is 2'b00, 2'b01 or 2'b11 for a captured loop strap of low, mid or high. It is 2'b00 while `straps_valid` is 0, and the software inputs never change it.
- R6: With `sw_mode_en` = 0, the mode comes from `mode_readback`: 00 selects low bandwidth, 01 selects bypass and 11 selects high bandwidth. Exactly one mode output is high while valid, and none is high before.
- R7: With `sw_mode_en` = 1, `sw_mode` sets the mode once valid: 00 selects low bandwidth, 01 selects bypass, and 10 or 11 selects high bandwidth.
- R8: `freq_code` equals `sw_freq` while `sw_freq_en` = 1 and is 2'b00 (100 MHz) otherwise. The other codes are 01 for 50 MHz, 10 for 125 MHz and 11 for 133.33 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; models power-up |
| pd_n | input | 1 | Active-low power-down; its first high triggers the capture |
| addr_strap | input | 2 | Level code of the address strap |
| bw_strap | input | 2 | Level code of the loop-mode strap |
| sw_mode_en | input | 1 | Enables the software mode override |
| sw_mode | input | 2 | Software mode code |
| sw_freq_en | input | 1 | Enables the software frequency select |
| sw_freq | input | 2 | Software frequency code |
| straps_valid | output | 1 | Straps have been captured |
| addr_low | output | 3 | Low bits of the management address |
| mode_readback | output | 2 | Read-only code of the captured loop strap |
| mode_low_bw | output | 1 | Low-bandwidth loop selected |
| mode_bypass | output | 1 | Loop bypass selected |
| mode_high_bw | output | 1 | High-bandwidth loop selected |
| freq_code | output | 2 | Effective frequency code |

## Verification
The assertions assume that `pd_n` and both strap codes are synchronous to `clk` and already settled at each edge. They also assume that reset is held for at least one edge before any capture is judged. The stimulus changes every input only shortly after a falling edge. It asserts reset over several edges between scenarios. It drives all four level codes, including the redundant 2'b11, on both straps.

// File: rtl/strap_pkg.sv
// Package: shared widths, level encoding and the fixed decode functions
// used by the strap latch and mode resolver. Assumes level codes arrive
// already reduced from the three-level pad sensor.
package strap_pkg;
    localparam int STRAP_W    = 2;
    localparam int ADDR_LOW_W = 3;
    localparam int MODE_W     = 2;
    localparam int FREQ_W     = 2;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } level_e;

    // Reduce a raw strap code to a level; 2'b11 counts as high.
    function automatic level_e level_of(input logic [STRAP_W-1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b01:   return LVL_MID;
            default: return LVL_HIGH;
        endcase
    endfunction

    // Address low bits for a captured address level.
    function automatic logic [ADDR_LOW_W-1:0] addr_low_of(input level_e lvl);
        case (lvl)
            LVL_LOW: return 3'b011;
            LVL_MID: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    // Readback mode code for a captured loop-strap level.
    function automatic logic [MODE_W-1:0] mode_code_of(input level_e lvl);
        case (lvl)
            LVL_LOW: return 2'b00;
            LVL_MID: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction
endpackage

// File: rtl/strap_capture.sv
// strap_capture: holds NUM_STRAPS strap codes, sampled once in the first
// cycle after reset with pd_n high. Assumes pd_n and the straps are
// synchronous to clk. Only reset clears the held values.
module strap_capture #(
    parameter int NUM_STRAPS = 2,
    parameter int STRAP_W    = 2,
    localparam int FLAT_W    = NUM_STRAPS * STRAP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic [FLAT_W-1:0] straps_in,
    output logic              valid,
    output logic [FLAT_W-1:0] straps_held
);
    logic take;
    assign take = pd_n && !valid;

    // Sticky flag: set by the first sampled pd_n high.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else if (take) valid <= 1'b1;
    end

    for (genvar s = 0; s < NUM_STRAPS; s++) begin : g_strap
        // Capture register for one strap.
        always_ff @(posedge clk) begin
            if (!rst_n) straps_held[s*STRAP_W +: STRAP_W] <= '0;
            else if (take) straps_held[s*STRAP_W +: STRAP_W] <= straps_in[s*STRAP_W +: STRAP_W];
        end
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid); // R1
    AST_FIRST_HIGH_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !valid) |=> (valid && straps_held == $past(straps_in))); // R2
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> $stable(straps_held)); // R2
endmodule

// File: rtl/mode_select.sv
// mode_select: builds the readback code from the held loop strap and
// picks the effective mode from that code or from the software code.
// Assumes the held strap is constant while valid is high.
module mode_select
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [STRAP_W-1:0] bw_held,
    input  logic              sw_en,
    input  logic [MODE_W-1:0] sw_code,
    output logic [MODE_W-1:0] rb_code,
    output logic              low_bw,
    output logic              bypass,
    output logic              high_bw
);
    logic [MODE_W-1:0] eff_code;

    // Readback follows the strap only; it is zero before capture.
    always_comb rb_code = valid ? mode_code_of(level_of(bw_held)) : '0;

    // Software code wins while enabled; otherwise the strap code applies.
    always_comb eff_code = sw_en ? sw_code : rb_code;

    // Decode to one-hot mode lines; 10 and 11 both mean high bandwidth.
    always_comb begin
        low_bw  = valid && (eff_code == 2'b00);
        bypass  = valid && (eff_code == 2'b01);
        high_bw = valid && eff_code[1];
    end

    AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($countones({low_bw, bypass, high_bw}) == 1)); // R6
    AST_NO_MODE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !(low_bw || bypass || high_bw)); // R6
    AST_RB_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rb_code != 2'b10); // R5
    AST_SW_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sw_en && sw_code == 2'b01) |-> bypass); // R7
endmodule

// File: rtl/freq_select.sv
// freq_select: passes the software frequency code while enabled and the
// 100 MHz default code otherwise. Purely combinational.
module freq_select
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_en,
    input  logic [FREQ_W-1:0] sw_code,
    output logic [FREQ_W-1:0] freq
);
    // Gate the software code with its enable.
    always_comb freq = sw_en ? sw_code : '0;

    AST_FREQ_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> (freq == 2'b00)); // R8
endmodule

// File: rtl/strap_mode_ctrl.sv
// strap_mode_ctrl: top. Captures the address and loop straps once per
// reset, then drives the address low bits, the mode readback, the
// effective mode and the frequency code. Assumes synchronous inputs.
module strap_mode_ctrl
    import strap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_n,
    input  logic [STRAP_W-1:0]    addr_strap,
    input  logic [STRAP_W-1:0]    bw_strap,
    input  logic                  sw_mode_en,
    input  logic [MODE_W-1:0]     sw_mode,
    input  logic                  sw_freq_en,
    input  logic [FREQ_W-1:0]     sw_freq,
    output logic                  straps_valid,
    output logic [ADDR_LOW_W-1:0] addr_low,
    output logic [MODE_W-1:0]     mode_readback,
    output logic                  mode_low_bw,
    output logic                  mode_bypass,
    output logic                  mode_high_bw,
    output logic [FREQ_W-1:0]     freq_code
);
    localparam int NUM_STRAPS = 2;
    localparam int FLAT_W     = NUM_STRAPS * STRAP_W;

    logic [FLAT_W-1:0] held;

    strap_capture #(.NUM_STRAPS(NUM_STRAPS), .STRAP_W(STRAP_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .straps_in   ({bw_strap, addr_strap}),
        .valid       (straps_valid),
        .straps_held (held)
    );

    // Address low bits from the held address strap; zero before capture.
    always_comb addr_low = straps_valid ? addr_low_of(level_of(held[0 +: STRAP_W])) : '0;

    mode_select u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (straps_valid),
        .bw_held (held[STRAP_W +: STRAP_W]),
        .sw_en   (sw_mode_en),
        .sw_code (sw_mode),
        .rb_code (mode_readback),
        .low_bw  (mode_low_bw),
        .bypass  (mode_bypass),
        .high_bw (mode_high_bw)
    );

    freq_select u_freq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_en   (sw_freq_en),
        .sw_code (sw_freq),
        .freq    (freq_code)
    );

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid |-> (addr_low >= 3'd3 && addr_low <= 3'd5)); // R4
    AST_ADDR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !straps_valid |-> (addr_low == 3'd0)); // R4
endmodule

// File: tb/sim_strap_mode_ctrl.sv
module sim_strap_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b0;
    logic [1:0] addr_strap = 2'b00, bw_strap = 2'b00;
    logic sw_mode_en = 1'b0, sw_freq_en = 1'b0;
    logic [1:0] sw_mode = 2'b00, sw_freq = 2'b00;
    logic straps_valid, mode_low_bw, mode_bypass, mode_high_bw;
    logic [2:0] addr_low;
    logic [1:0] mode_readback, freq_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit ref_valid = 1'b0;
    int ref_addr_lvl = 0;
    int ref_bw_lvl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
        .addr_strap(addr_strap), .bw_strap(bw_strap),
        .sw_mode_en(sw_mode_en), .sw_mode(sw_mode),
        .sw_freq_en(sw_freq_en), .sw_freq(sw_freq),
        .straps_valid(straps_valid), .addr_low(addr_low),
        .mode_readback(mode_readback), .mode_low_bw(mode_low_bw),
        .mode_bypass(mode_bypass), .mode_high_bw(mode_high_bw),
        .freq_code(freq_code)
    );

    function automatic int lvl(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        return 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) ref_valid = 1'b0;
        else if (!ref_valid && pd_n) begin
            ref_valid = 1'b1;
            ref_addr_lvl = lvl(addr_strap);
            ref_bw_lvl = lvl(bw_strap);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // compare against the reference away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            int e_addr, e_rb, e_mode;
            e_addr = ref_valid ? 3 + ref_addr_lvl : 0;
            e_rb = !ref_valid ? 0 : (ref_bw_lvl == 0 ? 0 : (ref_bw_lvl == 1 ? 1 : 3));
            e_mode = sw_mode_en ? int'(sw_mode) : e_rb;
            check("R1 valid", int'(straps_valid), int'(ref_valid));
            check("R2 R3 R4 addr_low", int'(addr_low), e_addr);
            check("R2 R3 R5 readback", int'(mode_readback), e_rb);
            check("R6 R7 low_bw", int'(mode_low_bw), int'(ref_valid && e_mode == 0));
            check("R6 R7 bypass", int'(mode_bypass), int'(ref_valid && e_mode == 1));
            check("R6 R7 high_bw", int'(mode_high_bw), int'(ref_valid && e_mode >= 2));
            check("R8 freq", int'(freq_code), sw_freq_en ? int'(sw_freq) : 0);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; pd_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(1);
        // R1: reset state and idle before first pd_n high, straps wiggling
        do_reset;
        for (int c = 0; c < 4; c++) begin
            addr_strap = 2'(c); bw_strap = 2'(3 - c); step(1);
        end
        // first capture: low/mid
        addr_strap = 2'b00; bw_strap = 2'b01; pd_n = 1'b1; step(1);
        // R2: later changes and power-down cycles ignored
        addr_strap = 2'b10; bw_strap = 2'b10; step(2);
        pd_n = 1'b0; step(2); pd_n = 1'b1; step(2);
        // R7/R8: sweep all software codes
        for (int m = 0; m < 4; m++) begin
            sw_mode_en = 1'b1; sw_mode = 2'(m);
            sw_freq_en = 1'b1; sw_freq = 2'(m); step(1);
            sw_freq_en = 1'b0; step(1);
        end
        sw_mode_en = 1'b0; sw_freq = 2'b11; step(1);
        // R3: every strap code pair across reset cycles
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                do_reset;
                addr_strap = 2'(a); bw_strap = 2'(b); step(1);
                pd_n = 1'b1; step(1);
                addr_strap = ~addr_strap; bw_strap = ~bw_strap; step(1);
                sw_mode_en = 1'b1; sw_mode = 2'(b); step(1);
                sw_mode_en = 1'b0; step(1);
            end
        end
        // R1: pd_n already high when reset releases
        rst_n = 1'b0; pd_n = 1'b1; addr_strap = 2'b01; bw_strap = 2'b11; step(2);
        rst_n = 1'b1; step(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule